// File: doc/BRIEF.md
# Multi-Period Frequency Meter

This block measures the frequency of a slow external square-wave input against a reference clock of known rate. The input is synchronised and its rising edges are detected. Reference cycles are counted across a window of one, four, sixteen or sixty-four input periods. The count is then turned into a binary frequency code by a sequential divider. The result is reported as an unsigned 32-bit value with a fixed scale, by default one count per millihertz. Results that exceed the allowed maximum are replaced by an invalid code of all ones.

Software-facing logic picks the window length with a 2-bit range request. A 2-bit acknowledge echoes the range of the value currently shown. The acknowledge moves to a new range only when a result measured with that range is published. A gate input freezes the shown value and blocks range changes. A separate static-input detector can force the output to zero.

Top module: `freqmeas_top`

## Requirements
- R1: While reset is low and after its release, until the first result is published, `freqOut` is 0 and `rangeAck` is 00.
- R2: Range code r selects a window of 4^r input periods (00→1, 01→4, 10→16, 11→64). For a periodic input of P reference cycles, the published value is floor(REF_HZ·SCALE / P), because the window count is 4^r·P and the dividend is 4^r·REF_HZ·SCALE.
- R3: `rangeAck` changes only when a result is published, and then takes the range used for that result. Right after a new request it still shows the old range.
- R4: After a range request, the new range is acknowledged within (N_old + N_new + 1) input periods plus two division times of NUM_W cycles each, plus a few cycles.
- R5: While `gateEn` is high, `freqOut` and `rangeAck` hold their values. A window that starts while the gate is high keeps the previous range, so requests made under the gate are ignored.
- R6: A quotient above MAX_CODE is published as 0xFFFFFFFF. A quotient equal to MAX_CODE is published unchanged.
- R7: In the cycle after `inputStatic` is sampled high, `freqOut` is 0. The current window is abandoned, and measurement restarts once `inputStatic` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, rate REF_HZ |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Asynchronous input whose frequency is measured |
| rangeReq | input | 2 | Requested window length code |
| gateEn | input | 1 | Freeze published value and block range changes |
| inputStatic | input | 1 | Static-input flag from an external watchdog |
| freqOut | output | 32 | Published frequency code or 0xFFFFFFFF |
| rangeAck | output | 2 | Range of the currently published value |

## Verification
The assertions assume that `sigIn` toggles slowly relative to the reference clock, with at least a few cycles per level, so that rising edges never arrive back to back. They also assume that the reference count does not wrap within one window. The stimulus keeps to these limits: `sigIn` is driven at the falling clock edge, with periods of 99 to 250 reference cycles and a duty close to one half. Range, gate and static inputs change only between settled measurements or at deliberately chosen points. The random cases draw ranges 00 to 10 and periods whose expected code is computed by a bench function.

// File: rtl/freqmeas_pkg.sv
package freqmeas_pkg;
  typedef enum logic [1:0] {
    ST_ARM,
    ST_COUNT,
    ST_DIVIDE
  } measState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       clearCount;
    logic       runCount;
    logic       startDiv;
    logic       loadResult;
    logic [1:0] rangeSel;
  } dpStrobes_t;
endpackage

// File: rtl/freqmeas_datapath.sv
module freqmeas_datapath
  import freqmeas_pkg::*;
#(
  parameter int unsigned REF_HZ   = 1000000,
  parameter int unsigned SCALE    = 1000,
  parameter int unsigned MAX_CODE = 100000,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NUM_W    = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sigIn,
  input  logic        inputStatic,
  input  dpStrobes_t  strobes,
  output logic        sigRise,
  output logic        divBusy,
  output logic        divDone,
  output logic [31:0] freqOut
);
  localparam longint unsigned SCALE_K = longint'(REF_HZ) * longint'(SCALE);
  localparam int unsigned     BIT_W   = $clog2(NUM_W + 1);
  localparam logic [NUM_W-1:0] SCALE_VEC = NUM_W'(SCALE_K);

  // input synchroniser and edge detect
  logic [2:0] syncPipe;
  always_ff @(posedge clk) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[1:0], sigIn};
  end
  assign sigRise = syncPipe[1] & ~syncPipe[2];

  // reference-cycle counter, saturating
  logic [CNT_W-1:0] refCount;
  always_ff @(posedge clk) begin
    if (!rstN)                                   refCount <= '0;
    else if (strobes.clearCount)                 refCount <= '0;
    else if (strobes.runCount && refCount != '1) refCount <= refCount + 1'b1;
  end

  // restoring divider, one quotient bit per cycle
  logic [CNT_W:0]   remReg, divisorReg;
  logic [NUM_W-1:0] quoReg;
  logic [BIT_W-1:0] bitsLeft;
  logic [CNT_W+1:0] trial, diff;
  logic             trialGe;
  logic [NUM_W-1:0] dividend;

  assign dividend = SCALE_VEC << {strobes.rangeSel, 1'b0};
  assign trial    = {remReg, quoReg[NUM_W-1]};
  assign trialGe  = trial >= {1'b0, divisorReg};
  assign diff     = trial - {1'b0, divisorReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg     <= '0;
      divisorReg <= '0;
      quoReg     <= '0;
      bitsLeft   <= '0;
      divBusy    <= 1'b0;
      divDone    <= 1'b0;
    end else if (strobes.startDiv) begin
      remReg     <= '0;
      divisorReg <= {1'b0, refCount} + 1'b1;
      quoReg     <= dividend;
      bitsLeft   <= BIT_W'(NUM_W);
      divBusy    <= 1'b1;
      divDone    <= 1'b0;
    end else if (divBusy) begin
      remReg   <= trialGe ? diff[CNT_W:0] : trial[CNT_W:0];
      quoReg   <= {quoReg[NUM_W-2:0], trialGe};
      bitsLeft <= bitsLeft - 1'b1;
      if (bitsLeft == BIT_W'(1)) begin
        divBusy <= 1'b0;
        divDone <= 1'b1;
      end
    end else begin
      divDone <= 1'b0;
    end
  end

  // publish with saturation and static override
  logic overRange;
  assign overRange = quoReg > NUM_W'(MAX_CODE);

  always_ff @(posedge clk) begin
    if (!rstN)                   freqOut <= '0;
    else if (inputStatic)        freqOut <= '0;
    else if (strobes.loadResult) freqOut <= overRange ? 32'hFFFF_FFFF : quoReg[31:0];
  end

  assert_sat_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    freqOut != 32'hFFFF_FFFF |-> freqOut <= MAX_CODE);

  assert_static_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(inputStatic) |-> freqOut == 32'd0);

  assert_done_follows_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(divDone) |-> $fell(divBusy));
endmodule

// File: rtl/freqmeas_ctrl.sv
module freqmeas_ctrl
  import freqmeas_pkg::*;
#(
  parameter int unsigned RANGE_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RANGE_W-1:0] rangeReq,
  input  logic               gateEn,
  input  logic               inputStatic,
  input  logic               sigRise,
  input  logic               divBusy,
  input  logic               divDone,
  output dpStrobes_t         strobes,
  output logic [RANGE_W-1:0] rangeAck
);
  localparam int unsigned EDGE_W = 2 * ((1 << RANGE_W) - 1) + 1;

  measState_t         state;
  logic [RANGE_W-1:0] workRange;
  logic [EDGE_W-1:0]  edgeCnt;
  logic [EDGE_W-1:0]  periodsNeeded;
  logic               lastEdge;

  assign periodsNeeded = EDGE_W'(1) << {workRange, 1'b0};
  assign lastEdge      = (edgeCnt + 1'b1) == periodsNeeded;

  always_comb begin
    strobes            = '0;
    strobes.rangeSel   = workRange;
    strobes.clearCount = (state == ST_ARM) && sigRise && !inputStatic;
    strobes.runCount   = (state == ST_COUNT);
    strobes.startDiv   = (state == ST_COUNT) && sigRise && lastEdge && !inputStatic;
    strobes.loadResult = (state == ST_DIVIDE) && divDone && !gateEn && !inputStatic;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_ARM;
      workRange <= '0;
      edgeCnt   <= '0;
      rangeAck  <= '0;
    end else begin
      case (state)
        ST_ARM: if (strobes.clearCount) begin
          if (!gateEn) workRange <= rangeReq;
          edgeCnt <= '0;
          state   <= ST_COUNT;
        end
        ST_COUNT: begin
          if (inputStatic)           state <= ST_ARM;
          else if (strobes.startDiv) state <= ST_DIVIDE;
          else if (sigRise)          edgeCnt <= edgeCnt + 1'b1;
        end
        ST_DIVIDE: if (divDone) begin
          if (strobes.loadResult) rangeAck <= workRange;
          state <= ST_ARM;
        end
        default: state <= ST_ARM;
      endcase
    end
  end

  assert_ack_needs_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rangeAck) |-> $past(divDone));

  assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startDiv |-> !divBusy);

  assert_ack_gate_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(gateEn) |-> $stable(rangeAck));
endmodule

// File: rtl/freqmeas_top.sv
module freqmeas_top
  import freqmeas_pkg::*;
#(
  parameter int unsigned REF_HZ   = 1000000,
  parameter int unsigned SCALE    = 1000,
  parameter int unsigned MAX_CODE = 100000,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NUM_W    = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sigIn,
  input  logic [1:0]  rangeReq,
  input  logic        gateEn,
  input  logic        inputStatic,
  output logic [31:0] freqOut,
  output logic [1:0]  rangeAck
);
  dpStrobes_t strobes;
  logic       sigRise, divBusy, divDone;

  freqmeas_ctrl #(.RANGE_W(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .rangeReq(rangeReq), .gateEn(gateEn),
    .inputStatic(inputStatic), .sigRise(sigRise), .divBusy(divBusy),
    .divDone(divDone), .strobes(strobes), .rangeAck(rangeAck)
  );

  freqmeas_datapath #(
    .REF_HZ(REF_HZ), .SCALE(SCALE), .MAX_CODE(MAX_CODE),
    .CNT_W(CNT_W), .NUM_W(NUM_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .inputStatic(inputStatic),
    .strobes(strobes), .sigRise(sigRise), .divBusy(divBusy),
    .divDone(divDone), .freqOut(freqOut)
  );

  assert_gate_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(gateEn) && !$past(inputStatic) |-> $stable(freqOut));
endmodule

// File: tb/test_freqmeas_top.sv
module test_freqmeas_top;
  localparam int unsigned REF_HZ   = 10000;
  localparam int unsigned SCALE    = 1000;
  localparam int unsigned MAX_CODE = 100000;
  localparam int unsigned NUM_W    = 48;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sigIn = 1'b0;
  logic [1:0]  rangeReq = 2'b00;
  logic        gateEn = 1'b0;
  logic        inputStatic = 1'b0;
  logic [31:0] freqOut;
  logic [1:0]  rangeAck;

  int checks = 0;
  int fails = 0;
  int curPeriod = 200;
  int prevPeriod = 200;
  int prevRange = 0;
  int phase = 0;
  bit genOn = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  freqmeas_top #(.REF_HZ(REF_HZ), .SCALE(SCALE), .MAX_CODE(MAX_CODE),
                 .CNT_W(32), .NUM_W(NUM_W)) i_freqmeas_top (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .rangeReq(rangeReq),
    .gateEn(gateEn), .inputStatic(inputStatic), .freqOut(freqOut),
    .rangeAck(rangeAck)
  );

  // periodic input, driven at falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (genOn) begin
        phase = phase + 1;
        if (phase >= curPeriod) phase = 0;
        sigIn = (phase < curPeriod / 2);
      end
    end
  end

  function automatic logic [31:0] expCode(int p);
    longint q;
    q = (longint'(REF_HZ) * SCALE) / p;
    if (q > MAX_CODE) return 32'hFFFF_FFFF;
    return q[31:0];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  // apply range and period, check acknowledge latency and settled value
  task automatic measure(int rng, int p, string req);
    int nOld, nNew, maxP, bound, waited;
    nOld = 1 << (2 * prevRange);
    nNew = 1 << (2 * rng);
    maxP = (p > prevPeriod) ? p : prevPeriod;
    bound = (nOld + nNew + 1) * maxP + 2 * NUM_W + 10;
    curPeriod = p;
    rangeReq = 2'(rng);
    waited = 0;
    while (rangeAck != 2'(rng) && waited < bound) begin
      cycles(1);
      waited++;
    end
    check(rangeAck == 2'(rng), "R4", rangeAck, rng);
    cycles((2 * nNew + 2) * p + 2 * NUM_W + 20);
    check(freqOut == expCode(p), req, freqOut, expCode(p));
    check(rangeAck == 2'(rng), "R3", rangeAck, rng);
    prevRange = rng;
    prevPeriod = p;
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    cycles(5);
    check(freqOut == 0 && rangeAck == 0, "R1", {freqOut, 6'd0, rangeAck}, 0);
    rstN = 1'b1;
    genOn = 1'b1;
    cycles(30);
    check(freqOut == 0 && rangeAck == 0, "R1", {freqOut, 6'd0, rangeAck}, 0);

    measure(0, 200, "R2");
    measure(1, 250, "R2");
    // acknowledge must still show old range right after a request
    rangeReq = 2'd2;
    cycles(3);
    check(rangeAck == 2'd1, "R3", rangeAck, 1);
    measure(2, 160, "R2");
    measure(3, 100, "R2");
    measure(0, 99, "R6");
    check(freqOut == 32'hFFFF_FFFF, "R6", freqOut, 32'hFFFF_FFFF);
    measure(0, 100, "R6");

    // gate: value and range frozen, requests under gate ignored
    measure(0, 200, "R5");
    gateEn = 1'b1;
    rangeReq = 2'd2;
    curPeriod = 150;
    cycles(3000);
    check(freqOut == expCode(200), "R5", freqOut, expCode(200));
    check(rangeAck == 2'd0, "R5", rangeAck, 0);
    rangeReq = 2'd0;
    cycles(20);
    gateEn = 1'b0;
    cycles(4 * 150 + 2 * NUM_W + 20);
    check(freqOut == expCode(150), "R5", freqOut, expCode(150));
    check(rangeAck == 2'd0, "R5", rangeAck, 0);
    prevPeriod = 150;

    // static input forces zero
    inputStatic = 1'b1;
    cycles(1);
    check(freqOut == 0, "R7", freqOut, 0);
    cycles(10);
    check(freqOut == 0, "R7", freqOut, 0);
    inputStatic = 1'b0;
    measure(1, 220, "R7");

    for (int i = 0; i < 6; i++) begin
      int rr, pp;
      rr = int'($urandom % 3);
      pp = 100 + int'($urandom % 150);
      measure(rr, pp, "R2");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule